// File: doc/BRIEF.md
# Keyboard Command Responder

This block acts as the keyboard end of a serial link. The host's transmitter hands it command bytes through a strobe. The block decodes each accepted byte. A recognised command throws away whatever reply bytes are still waiting and loads a fixed reply burst into a small circular queue. A separate command arms a one-shot capture, and the byte after it is kept as the indicator (LED) state instead of being decoded.

The host drains replies one byte per read strobe. The byte appears on the read output one clock after the strobe. The data-available flag stays high for as long as the queue holds at least one byte. Reading an empty queue gives zero and changes nothing.

Top module: `kbd_cmd_responder`

## Requirements
- R1: After reset, `rx_avail` is 0, `rd_byte` is 0x00 and `led_state` is 0x00.
- R2: An accepted command 0x01 empties the queue. It then fills the queue with 0xFF, 0x04, 0x7F, read back in that order.
- R3: An accepted command 0x07 or 0x0F empties the queue. It then fills the queue with 0xFE, 0x00, read back in that order.
- R4: An accepted command 0x0E arms capture mode. The next accepted byte is copied to `led_state` and is not decoded, even when it equals a command code. Capture mode then ends.
- R5: Any other accepted byte leaves both the queue contents and `led_state` unchanged.
- R6: A `cmd_valid` pulse while `tx_en` is low has no effect on the queue, on `led_state` or on capture mode.
- R7: A read strobe on a non-empty queue puts the oldest byte on `rd_byte` in the next cycle and removes that byte. `rx_avail` stays high while bytes remain. Between strobes, `rd_byte` holds its value.
- R8: A read strobe on an empty queue sets `rd_byte` to 0x00 and leaves the queue unchanged.
- R9: Queue positions wrap at `DEPTH`. The stored byte count never exceeds `DEPTH`. Burst bytes beyond the capacity are dropped, and the leading bytes are kept.
- R10: A read strobe and an accepted burst command in the same cycle return the old head byte (or 0x00 if the queue was empty). Afterwards the queue holds exactly the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Host transmitter enabled; commands are taken only when high |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command or indicator byte |
| rd_strobe | input | 1 | Host data read request |
| rd_byte | output | 8 | Byte returned by the last read |
| rx_avail | output | 1 | High while the reply queue is not empty |
| led_state | output | 8 | Last captured indicator byte |

## Verification
Two cases are hard to reach from the ports.

The first is pointer wrap-around. Every burst first clears the queue, so the queue never fills up. Wrap-around therefore happens only when many partial drains push the read position around the ring. The stimulus gets there by alternating bursts with one or two reads over many rounds.

The second is the capacity drop. It cannot happen at the default depth. A second instance with a two-entry queue shows the third reset reply byte being discarded.

The same-cycle read-and-reload is driven directly, to show which byte wins.

// File: rtl/kbd_resp_pkg.sv
package kbd_resp_pkg;

  localparam logic [7:0] CMD_RESET    = 8'h01;
  localparam logic [7:0] CMD_LAYOUT_A = 8'h07;
  localparam logic [7:0] CMD_LAYOUT_B = 8'h0F;
  localparam logic [7:0] CMD_LEDSET   = 8'h0E;

  localparam int unsigned BURST_MAX = 3;
  localparam int unsigned LEN_W     = 2;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_RESET  = 2'd1,
    ACT_LAYOUT = 2'd2,
    ACT_LEDSET = 2'd3
  } kbd_act_e;

  function automatic kbd_act_e decode_cmd(input logic [7:0] b);
    case (b)
      CMD_RESET:                  return ACT_RESET;
      CMD_LAYOUT_A, CMD_LAYOUT_B: return ACT_LAYOUT;
      CMD_LEDSET:                 return ACT_LEDSET;
      default:                    return ACT_NONE;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] burst_len(input kbd_act_e a);
    case (a)
      ACT_RESET:  return LEN_W'(3);
      ACT_LAYOUT: return LEN_W'(2);
      default:    return LEN_W'(0);
    endcase
  endfunction

  function automatic logic [7:0] burst_byte(input kbd_act_e a, input int unsigned idx);
    if (a == ACT_RESET) begin
      case (idx)
        0:       return 8'hFF;
        1:       return 8'h04;
        2:       return 8'h7F;
        default: return 8'h00;
      endcase
    end else if (a == ACT_LAYOUT) begin
      case (idx)
        0:       return 8'hFE;
        default: return 8'h00;
      endcase
    end
    return 8'h00;
  endfunction

  function automatic int unsigned wrap_add(input int unsigned p, input int unsigned k,
                                           input int unsigned depth);
    return (p + k) % depth;
  endfunction

endpackage

// File: rtl/kbd_cmd_decoder.sv
module kbd_cmd_decoder
  import kbd_resp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tx_en,
  input  logic                          cmd_valid,
  input  logic [7:0]                    cmd_byte,
  output logic                          load_go,
  output logic [LEN_W-1:0]              load_len,
  output logic [BURST_MAX-1:0][7:0]     load_bytes,
  output logic [7:0]                    led_state,
  output logic                          led_mode
);

  logic     accepted;
  logic     capture_now;
  kbd_act_e act;

  assign accepted    = cmd_valid && tx_en;
  assign capture_now = accepted && led_mode;
  assign act         = decode_cmd(cmd_byte);

  assign load_go  = accepted && !led_mode && (act == ACT_RESET || act == ACT_LAYOUT);
  assign load_len = burst_len(act);

  for (genvar g = 0; g < BURST_MAX; g++) begin : g_bytes
    assign load_bytes[g] = burst_byte(act, g);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_mode  <= 1'b0;
      led_state <= 8'h00;
    end else if (capture_now) begin
      led_state <= cmd_byte;
      led_mode  <= 1'b0;
    end else if (accepted && act == ACT_LEDSET) begin
      led_mode <= 1'b1;
    end
  end

  a_r4_capture_once: assert property (@(posedge clk) disable iff (!rst_n)
    (led_mode && cmd_valid && tx_en) |=> (!led_mode && led_state == $past(cmd_byte)));

  a_r4_no_decode_in_capture: assert property (@(posedge clk) disable iff (!rst_n)
    led_mode |-> !load_go);

  a_r6_disabled_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> ($stable(led_state) && $stable(led_mode)));

endmodule

// File: rtl/kbd_reply_fifo.sv
module kbd_reply_fifo
  import kbd_resp_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_go,
  input  logic [LEN_W-1:0]          load_len,
  input  logic [BURST_MAX-1:0][7:0] load_bytes,
  input  logic                      pop_req,
  output logic [7:0]                head,
  output logic                      empty
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rptr;
  logic [CW-1:0] count;
  logic [CW-1:0] store_n;
  logic          pop_fire;
  logic          slot_en   [BURST_MAX];
  logic [PW-1:0] slot_addr [BURST_MAX];

  assign store_n  = (32'(load_len) > DEPTH) ? CW'(DEPTH) : CW'(load_len);
  assign pop_fire = pop_req && !load_go && (count != '0);

  for (genvar g = 0; g < BURST_MAX; g++) begin : g_slot
    assign slot_en[g]   = load_go && (32'(store_n) > g);
    assign slot_addr[g] = PW'(wrap_add(32'(rptr), g, DEPTH));
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < BURST_MAX; s++) begin
      if (slot_en[s]) mem[slot_addr[s]] <= load_bytes[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr  <= '0;
      count <= '0;
    end else if (load_go) begin
      count <= store_n;
    end else if (pop_fire) begin
      rptr  <= PW'(wrap_add(32'(rptr), 1, DEPTH));
      count <= count - CW'(1);
    end
  end

  assign empty = (count == '0);
  assign head  = empty ? 8'h00 : mem[rptr];

  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r2_load_replaces: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> (count == $past(store_n)));

  a_r7_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !load_go && !empty) |=> (count == $past(count) - CW'(1)));

  a_r8_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !load_go) |=> (empty && $stable(rptr)));

  a_r10_load_beats_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && pop_req) |=> $stable(rptr));

endmodule

// File: rtl/kbd_read_port.sv
module kbd_read_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_strobe,
  input  logic [7:0] head,
  input  logic       empty,
  output logic [7:0] rd_byte
);

  always_ff @(posedge clk) begin
    if (!rst_n)         rd_byte <= 8'h00;
    else if (rd_strobe) rd_byte <= empty ? 8'h00 : head;
  end

  a_r8_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && empty) |=> (rd_byte == 8'h00));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_byte));

endmodule

// File: rtl/kbd_cmd_responder.sv
module kbd_cmd_responder
  import kbd_resp_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       rd_strobe,
  output logic [7:0] rd_byte,
  output logic       rx_avail,
  output logic [7:0] led_state
);

  logic                      load_go;
  logic [LEN_W-1:0]          load_len;
  logic [BURST_MAX-1:0][7:0] load_bytes;
  logic                      led_mode;
  logic [7:0]                head;
  logic                      empty;

  kbd_cmd_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .load_go   (load_go),
    .load_len  (load_len),
    .load_bytes(load_bytes),
    .led_state (led_state),
    .led_mode  (led_mode)
  );

  kbd_reply_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_go   (load_go),
    .load_len  (load_len),
    .load_bytes(load_bytes),
    .pop_req   (rd_strobe),
    .head      (head),
    .empty     (empty)
  );

  kbd_read_port u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_strobe(rd_strobe),
    .head     (head),
    .empty    (empty),
    .rd_byte  (rd_byte)
  );

  assign rx_avail = !empty;

  a_r6_ignored_no_avail: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_avail && !(cmd_valid && tx_en)) |=> !rx_avail);

endmodule

// File: tb/tb_kbd_cmd_responder.sv
`timescale 1ns/1ps
module tb_kbd_cmd_responder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, cmd_valid = 1'b0, rd_strobe = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] rd_byte, led_state;
  logic       rx_avail;

  logic       s_tx_en = 1'b0, s_cmd_valid = 1'b0, s_rd = 1'b0;
  logic [7:0] s_cmd = 8'h00;
  logic [7:0] s_rd_byte, s_led;
  logic       s_avail;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  kbd_cmd_responder dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .rd_strobe(rd_strobe), .rd_byte(rd_byte), .rx_avail(rx_avail), .led_state(led_state));

  kbd_cmd_responder #(.DEPTH(2)) dut_small (
    .clk(clk), .rst_n(rst_n), .tx_en(s_tx_en), .cmd_valid(s_cmd_valid), .cmd_byte(s_cmd),
    .rd_strobe(s_rd), .rd_byte(s_rd_byte), .rx_avail(s_avail), .led_state(s_led));

  // bench model of the main instance
  byte unsigned model_q[$];
  bit           m_led_mode = 0;
  byte unsigned m_led = 0;
  // scoreboard
  byte unsigned exp_q[$];
  string        tag_q[$];
  logic         rd_seen = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_strobe;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() != 0) begin
      byte unsigned e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rd_byte == e, t, rd_byte, e);
    end
  end

  task automatic drive(input logic cv, input logic en, input logic [7:0] b,
                       input logic rd, input string tag);
    bit load;
    byte unsigned burst[$];
    load = 0;
    @(negedge clk);
    cmd_valid = cv; tx_en = en; cmd_byte = b; rd_strobe = rd;
    if (rd) begin
      exp_q.push_back(model_q.size() != 0 ? model_q[0] : 8'h00);
      tag_q.push_back(tag);
    end
    if (cv && en) begin
      if (m_led_mode) begin
        m_led = b; m_led_mode = 0;
      end else if (b == 8'h01) begin
        load = 1; burst = '{8'hFF, 8'h04, 8'h7F};
      end else if (b == 8'h07 || b == 8'h0F) begin
        load = 1; burst = '{8'hFE, 8'h00};
      end else if (b == 8'h0E) begin
        m_led_mode = 1;
      end
    end
    if (rd && !load && model_q.size() != 0) void'(model_q.pop_front());
    if (load) begin
      model_q.delete();
      foreach (burst[i]) if (model_q.size() < 16) model_q.push_back(burst[i]);
    end
    @(negedge clk);
    cmd_valid = 1'b0; rd_strobe = 1'b0;
    check(rx_avail == (model_q.size() != 0), {tag, " rx_avail"}, rx_avail, model_q.size() != 0);
    check(led_state == m_led, {tag, " led_state"}, led_state, m_led);
  endtask

  task automatic cmd(input logic [7:0] b, input string tag);
    drive(1'b1, 1'b1, b, 1'b0, tag);
  endtask
  task automatic rd(input string tag);
    drive(1'b0, 1'b1, 8'h00, 1'b1, tag);
  endtask

  task automatic s_step(input logic cv, input logic [7:0] b, input logic r);
    @(negedge clk);
    s_cmd_valid = cv; s_tx_en = 1'b1; s_cmd = b; s_rd = r;
    @(negedge clk);
    s_cmd_valid = 1'b0; s_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rx_avail == 1'b0, "R1 rx_avail", rx_avail, 0);
    check(rd_byte == 8'h00, "R1 rd_byte", rd_byte, 0);
    check(led_state == 8'h00, "R1 led_state", led_state, 0);
    check(s_avail == 1'b0, "R1 small rx_avail", s_avail, 0);

    // R8 empty read
    rd("R8 empty read");

    // R2 reset burst and drain
    cmd(8'h01, "R2 reset cmd");
    repeat (3) rd("R2 reset reply");
    rd("R8 read after drain");

    // R3 layout bursts, replacing partial queue
    cmd(8'h07, "R3 layout 07");
    rd("R3 layout head");
    cmd(8'h0F, "R3 layout 0F replaces");
    repeat (2) rd("R3 layout reply");

    // R5 unknown codes ignored
    cmd(8'h01, "R2 reload");
    cmd(8'h55, "R5 unknown 55");
    cmd(8'h02, "R5 unknown 02");
    cmd(8'hFF, "R5 unknown FF");
    repeat (3) rd("R5 queue intact");

    // R6 transmitter disabled
    drive(1'b1, 1'b0, 8'h07, 1'b0, "R6 disabled 07");
    drive(1'b1, 1'b0, 8'h0E, 1'b0, "R6 disabled 0E");
    cmd(8'h21, "R6 byte after disabled 0E not captured");

    // R4 capture mode
    cmd(8'h0E, "R4 arm");
    cmd(8'h01, "R4 captured 01 not decoded");
    drive(1'b1, 1'b0, 8'hAA, 1'b0, "R6 disabled during arm");
    cmd(8'h0E, "R4 re-arm");
    drive(1'b1, 1'b0, 8'hAA, 1'b0, "R6 disabled in capture");
    cmd(8'h3C, "R4 capture 3C");
    cmd(8'h01, "R4 decoded again");
    rd("R4 reply after capture");

    // R10 simultaneous read and reload
    drive(1'b1, 1'b1, 8'h07, 1'b1, "R10 read with reload");
    repeat (2) rd("R10 new burst");
    drive(1'b1, 1'b1, 8'h01, 1'b1, "R10 empty read with reload");
    repeat (3) rd("R10 reset burst");

    // R9 wrap: advance the read position around the ring
    for (int k = 0; k < 24; k++) begin
      cmd((k % 3 == 0) ? 8'h0F : 8'h01, "R9 wrap load");
      rd("R9 wrap read");
      if (k % 2 == 1) rd("R9 wrap read2");
    end
    repeat (3) rd("R9 wrap tail");

    // R7 rd_byte holds while idle
    begin
      logic [7:0] held;
      held = rd_byte;
      repeat (4) @(negedge clk);
      check(rd_byte == held, "R7 rd_byte hold", rd_byte, held);
    end

    // R9 capacity on the two-entry instance
    s_step(1'b1, 8'h01, 1'b0);
    check(s_avail == 1'b1, "R9 small avail", s_avail, 1);
    s_step(1'b0, 8'h00, 1'b1);
    check(s_rd_byte == 8'hFF, "R9 small first", s_rd_byte, 8'hFF);
    s_step(1'b0, 8'h00, 1'b1);
    check(s_rd_byte == 8'h04, "R9 small second", s_rd_byte, 8'h04);
    check(s_avail == 1'b0, "R9 third byte dropped", s_avail, 0);
    s_step(1'b0, 8'h00, 1'b1);
    check(s_rd_byte == 8'h00, "R9 small empty read", s_rd_byte, 0);
    s_step(1'b1, 8'h07, 1'b0);
    s_step(1'b0, 8'h00, 1'b1);
    check(s_rd_byte == 8'hFE, "R9 small wrap first", s_rd_byte, 8'hFE);
    check(s_avail == 1'b1, "R9 small wrap avail", s_avail, 1);
    s_step(1'b0, 8'h00, 1'b1);
    check(s_rd_byte == 8'h00, "R9 small wrap second", s_rd_byte, 0);
    check(s_avail == 1'b0, "R9 small drained", s_avail, 0);

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule